// File: doc/BRIEF.md
# AXI4 Write-Channel Rule Monitor

This block is a passive observer for the write address and write data channels of an AXI4 link between a master and a slave. It drives none of the bus signals; it only samples them. It enforces two protocol rules. The first is that an incrementing burst stays inside a single 4096-byte address page. The second is that a write beat which the slave is stalling keeps its payload unchanged until the handshake completes.

Each broken rule raises its own sticky flag. A 2-bit code records which rule was broken first. A synchronous clear input re-arms the monitor without resetting the link. The block is meant to sit beside a master during integration or in an emulation build, so that a burst that wraps past a page or a beat that mutates under backpressure is caught at the cycle it happens.

Top module: `axi_wr_rule_monitor`

## Requirements
- R1: After the active-low reset `aresetn` is released, `page_err`, `hold_err` and `err_code` are all 0.
- R2: Burst-type encoding is 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping. For an incrementing burst, the last byte address is start + (len+1)·2^size − 1. If bits [31:12] of the start and last byte addresses differ, `page_err` is set at the clock edge that ends the handshake cycle.
- R3: A 16-beat, 4-byte burst (len=15, size=2) is judged as follows. At page offset 0xFC8 it is flagged. At offset 0x000 it is not flagged. At offset 0xFC0, where it ends exactly at 0xFFF, it is not flagged.
- R4: Fixed and wrapping bursts never set `page_err`, whatever their address and length.
- R5: The address fields are judged only in a cycle where `aw_valid` and `aw_ready` are both 1. A crossing burst presented with `aw_ready`=0 raises no flag.
- R6: Suppose a clock edge samples `w_valid`=1 and `w_ready`=0. If `w_data`, `w_strb` or `w_last` then differs from its sampled value in the next cycle, `hold_err` is set at the following edge.
- R7: `w_valid` falling to 0 while a beat is stalled also sets `hold_err`.
- R8: Payload changes while no beat is stalled (`w_ready`=1 or `w_valid`=0 at the previous edge) set no flag.
- R9: Once set, each flag and the code stay set until `clr` is sampled high or `aresetn` is asserted.
- R10: `err_code` is 0 when nothing has been seen, 1 for a page crossing and 2 for a payload-hold violation. It keeps the first violation recorded. When both violations appear in the same cycle it reports 1.
- R11: `clr` is synchronous and wins over a violation sampled in the same cycle. After that edge all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of flags and code |
| aw_addr | input | 32 | Burst start byte address |
| aw_len | input | 8 | Beats in burst minus one |
| aw_size | input | 3 | Log2 of bytes per beat |
| aw_burst | input | 2 | Burst type |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Byte strobes |
| w_last | input | 1 | Last beat marker |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| page_err | output | 1 | Sticky page-crossing flag |
| hold_err | output | 1 | Sticky payload-hold flag |
| err_code | output | 2 | First violation seen |

## Verification
The hardest situation to reach from the ports is two violations in one cycle. This needs an address handshake carrying a crossing burst in exactly the cycle after a stalled data beat, with the payload altered in that same cycle. The bench builds it by stalling a beat, then driving the crossing handshake and the changed data together at the next edge. It builds a clear landing on a crossing handshake in the same way. A behavioural model tracks stalls and page arithmetic independently and is compared every clock.

// File: rtl/axi_mon_pkg.sv
package axi_mon_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_PAGE = 2'd1,
    ERR_HOLD = 2'd2
  } err_code_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/axi_rst_sync.sv
module axi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/axi_page_check.sv
module axi_page_check #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  input  logic              valid,
  input  logic              ready,
  output logic              cross_hit
);
  import axi_mon_pkg::*;

  localparam int SPAN_W = LEN_W + 1 + 7;
  localparam int SUM_W  = ADDR_W + 1;

  logic [SPAN_W-1:0] beats;
  logic [SPAN_W-1:0] span;
  logic [SUM_W-1:0]  last_byte;
  logic [SUM_W-1:0]  first_byte;
  logic              differs;

  always_comb begin
    beats      = SPAN_W'(len) + SPAN_W'(1);
    span       = beats << size;
    first_byte = SUM_W'(addr);
    last_byte  = first_byte + SUM_W'(span) - SUM_W'(1);
    differs    = last_byte[SUM_W-1:PAGE_BITS] != first_byte[SUM_W-1:PAGE_BITS];
    cross_hit  = valid && ready && (burst == BURST_INCR) && differs;
  end
endmodule

// File: rtl/axi_hold_check.sv
module axi_hold_check #(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data,
  input  logic [STRB_W-1:0] strb,
  input  logic              last,
  input  logic              valid,
  input  logic              ready,
  output logic              viol
);
  localparam int SNAP_W = DATA_W + STRB_W + 1;

  logic              stall_q, stall_d;
  logic [SNAP_W-1:0] snap_q, snap_d;
  logic              snap_en;
  logic [SNAP_W-1:0] now_beat;

  always_comb begin
    now_beat = {data, strb, last};
    stall_d  = valid && !ready;
    snap_en  = stall_d;
    snap_d   = snap_en ? now_beat : snap_q;
    viol     = stall_q && (!valid || (now_beat != snap_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      stall_q <= stall_d;
      snap_q  <= snap_d;
    end
  end

  // A violation is only possible one cycle after a stalled beat was sampled
  assert_viol_after_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(valid && !ready));
endmodule

// File: rtl/axi_err_latch.sv
module axi_err_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       page_hit,
  input  logic       hold_hit,
  output logic       page_err,
  output logic       hold_err,
  output logic [1:0] err_code
);
  import axi_mon_pkg::*;

  logic      page_q, page_d;
  logic      hold_q, hold_d;
  err_code_e code_q, code_d;

  always_comb begin
    page_d = page_q;
    hold_d = hold_q;
    code_d = code_q;
    if (clr) begin
      page_d = 1'b0;
      hold_d = 1'b0;
      code_d = ERR_NONE;
    end else begin
      page_d = page_q || page_hit;
      hold_d = hold_q || hold_hit;
      if (code_q == ERR_NONE) begin
        if (page_hit)      code_d = ERR_PAGE;
        else if (hold_hit) code_d = ERR_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      hold_q <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      page_q <= page_d;
      hold_q <= hold_d;
      code_q <= code_d;
    end
  end

  assign page_err = page_q;
  assign hold_err = hold_q;
  assign err_code = code_q;

  assert_page_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    page_q && !clr |=> page_q);
  assert_hold_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !clr |=> hold_q);
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!page_q && !hold_q && code_q == ERR_NONE));
  assert_code_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != ERR_NONE) && !clr |=> $stable(code_q));
  assert_code_matches_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q || hold_q) == (code_q != ERR_NONE));
endmodule

// File: rtl/axi_wr_rule_monitor.sv
module axi_wr_rule_monitor #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int PAGE_BITS = 12,
  parameter int STRB_W    = DATA_W / 8
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic              clr,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  input  logic              w_valid,
  input  logic              w_ready,
  output logic              page_err,
  output logic              hold_err,
  output logic [1:0]        err_code
);
  logic rst_s_n;
  logic page_hit;
  logic hold_hit;

  axi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (aclk),
    .arst_n (aresetn),
    .srst_n (rst_s_n)
  );

  axi_page_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
  ) u_page_check (
    .addr      (aw_addr),
    .len       (aw_len),
    .size      (aw_size),
    .burst     (aw_burst),
    .valid     (aw_valid),
    .ready     (aw_ready),
    .cross_hit (page_hit)
  );

  axi_hold_check #(.DATA_W(DATA_W), .STRB_W(STRB_W)) u_hold_check (
    .clk   (aclk),
    .rst_n (rst_s_n),
    .data  (w_data),
    .strb  (w_strb),
    .last  (w_last),
    .valid (w_valid),
    .ready (w_ready),
    .viol  (hold_hit)
  );

  axi_err_latch u_err_latch (
    .clk      (aclk),
    .rst_n    (rst_s_n),
    .clr      (clr),
    .page_hit (page_hit),
    .hold_hit (hold_hit),
    .page_err (page_err),
    .hold_err (hold_err),
    .err_code (err_code)
  );

  assert_page_flag_set_R2: assert property (@(posedge aclk) disable iff (!rst_s_n)
    page_hit && !clr |=> page_err);
  assert_page_needs_handshake_R5: assert property (@(posedge aclk) disable iff (!rst_s_n)
    !(aw_valid && aw_ready) && !page_err && !clr |=> !page_err || $past(page_hit));
  assert_fixed_wrap_exempt_R4: assert property (@(posedge aclk) disable iff (!rst_s_n)
    (aw_burst != 2'b01) |-> !page_hit);
endmodule

// File: tb/axi_wr_rule_monitor_bench.sv
`timescale 1ns/1ps
module axi_wr_rule_monitor_bench;
  logic        aclk = 1'b0;
  logic        aresetn;
  logic        clr;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst;
  logic        aw_valid, aw_ready;
  logic [31:0] w_data;
  logic [3:0]  w_strb;
  logic        w_last, w_valid, w_ready;
  logic        page_err, hold_err;
  logic [1:0]  err_code;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit run_cmp = 1'b0;

  always #2.5 aclk = ~aclk;

  axi_wr_rule_monitor u_axi_wr_rule_monitor (
    .aclk(aclk), .aresetn(aresetn), .clr(clr),
    .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .w_valid(w_valid), .w_ready(w_ready),
    .page_err(page_err), .hold_err(hold_err), .err_code(err_code)
  );

  // behavioural reference
  bit          m_page, m_hold, m_stall;
  int          m_code;
  logic [31:0] m_d;
  logic [3:0]  m_s;
  logic        m_l;

  always @(posedge aclk or negedge aresetn) begin
    if (!aresetn) begin
      m_page = 0; m_hold = 0; m_code = 0; m_stall = 0;
      m_d = 0; m_s = 0; m_l = 0;
    end else begin
      longint first, lastb;
      bit pc, hv;
      first = aw_addr;
      lastb = first + ((longint'(aw_len) + 1) << aw_size) - 1;
      pc = aw_valid && aw_ready && aw_burst == 2'b01 && ((first >> 12) != (lastb >> 12));
      hv = m_stall && (!w_valid || w_data != m_d || w_strb != m_s || w_last != m_l);
      if (clr) begin
        m_page = 0; m_hold = 0; m_code = 0;
      end else begin
        if (m_code == 0) m_code = pc ? 1 : (hv ? 2 : 0);
        m_page = m_page | pc;
        m_hold = m_hold | hv;
      end
      m_stall = w_valid && !w_ready;
      if (m_stall) begin m_d = w_data; m_s = w_strb; m_l = w_last; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge aclk) begin
    if (run_cmp && aresetn) begin
      chk("R2 model page_err", page_err, m_page);
      chk("R6 model hold_err", hold_err, m_hold);
      chk("R10 model err_code", err_code, m_code);
    end
  end

  always @(posedge aclk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge aclk);
  endtask

  task automatic idle();
    aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; clr = 0;
  endtask

  task automatic aw_beat(logic [31:0] a, logic [7:0] l, logic [2:0] s, logic [1:0] b, logic rdy);
    aw_addr = a; aw_len = l; aw_size = s; aw_burst = b; aw_valid = 1; aw_ready = rdy;
    tick();
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic do_clear();
    clr = 1; tick(); clr = 0;
  endtask

  task automatic expect_out(string tag, int p, int h, int c);
    chk({tag, " page_err"}, page_err, p);
    chk({tag, " hold_err"}, hold_err, h);
    chk({tag, " err_code"}, err_code, c);
  endtask

  initial begin
    aresetn = 0; clr = 0;
    aw_addr = 0; aw_len = 0; aw_size = 0; aw_burst = 0; aw_valid = 0; aw_ready = 0;
    w_data = 0; w_strb = 0; w_last = 0; w_valid = 0; w_ready = 0;
    tick(5);
    aresetn = 1;
    tick(4);
    run_cmp = 1;
    expect_out("R1 after reset", 0, 0, 0);

    // R3: aligned and exactly-ending bursts pass
    aw_beat(32'h44A0_0000, 8'd15, 3'd2, 2'b01, 1'b1);
    expect_out("R3 aligned burst", 0, 0, 0);
    aw_beat(32'h44A0_0FC0, 8'd15, 3'd2, 2'b01, 1'b1);
    expect_out("R3 ends at 0xFFF", 0, 0, 0);

    // R4: fixed and wrapping exempt
    aw_beat(32'h44A0_0FC8, 8'd15, 3'd2, 2'b00, 1'b1);
    aw_beat(32'h44A0_0FF0, 8'd15, 3'd3, 2'b10, 1'b1);
    expect_out("R4 fixed and wrap", 0, 0, 0);

    // R5: valid without ready
    aw_beat(32'h44A0_0FC8, 8'd15, 3'd2, 2'b01, 1'b0);
    tick();
    expect_out("R5 no handshake", 0, 0, 0);

    // R8: changes with ready high, then with valid low
    w_valid = 1; w_ready = 1; w_data = 32'h11; w_strb = 4'hF;
    tick(); w_data = 32'h22; w_strb = 4'h3; w_last = 1;
    tick(); w_valid = 0; w_data = 32'h33;
    tick(); w_data = 32'h44; w_last = 0;
    tick();
    expect_out("R8 no stall changes", 0, 0, 0);

    // R6: steady stall then handshake is legal
    w_valid = 1; w_ready = 0; w_data = 32'hA5A5_0001; w_strb = 4'hF; w_last = 0;
    tick(3); w_ready = 1;
    tick(); w_valid = 0; w_ready = 0;
    tick();
    expect_out("R6 stable stall", 0, 0, 0);

    // R2/R3: crossing burst flagged, code 1
    aw_beat(32'h44A0_0FC8, 8'd15, 3'd2, 2'b01, 1'b1);
    expect_out("R3 0xFC8 burst", 1, 0, 1);

    // R10: later hold violation keeps code 1
    w_valid = 1; w_ready = 0; w_data = 32'h5; tick();
    w_data = 32'h6; tick();
    w_valid = 0;
    expect_out("R10 first kept", 1, 1, 1);
    tick(5);
    expect_out("R9 sticky", 1, 1, 1);

    // R11: clear
    do_clear();
    expect_out("R11 cleared", 0, 0, 0);

    // R6: strobe change under stall, code 2
    w_valid = 1; w_ready = 0; w_data = 32'h7; w_strb = 4'hF; tick();
    w_strb = 4'h1; tick();
    w_valid = 0;
    expect_out("R6 strobe change", 0, 1, 2);
    do_clear();

    // R6: last change under stall
    w_valid = 1; w_ready = 0; w_last = 0; tick();
    w_last = 1; tick();
    w_valid = 0; w_last = 0;
    chk("R6 last change hold_err", hold_err, 1);
    do_clear();

    // R2: small burst size 3 crossing at 0xFFC
    aw_beat(32'h0000_0FFC, 8'd0, 3'd3, 2'b01, 1'b1);
    chk("R2 8-byte beat crossing", page_err, 1);
    do_clear();

    // R11: clear in same cycle as a crossing handshake
    clr = 1;
    aw_beat(32'h44A0_0FC8, 8'd15, 3'd2, 2'b01, 1'b1);
    clr = 0;
    expect_out("R11 clear wins", 0, 0, 0);

    // R7: valid drops during stall
    w_valid = 1; w_ready = 0; w_data = 32'h9; tick();
    w_valid = 0; tick();
    expect_out("R7 valid dropped", 0, 1, 2);
    do_clear();

    // R10: both in the same cycle -> code 1
    w_valid = 1; w_ready = 0; w_data = 32'hC; tick();
    w_data = 32'hD;
    aw_beat(32'h44A0_0FC8, 8'd15, 3'd2, 2'b01, 1'b1);
    w_valid = 0;
    expect_out("R10 simultaneous", 1, 1, 1);

    // R9/R1: reset clears
    run_cmp = 0;
    aresetn = 0; tick();
    expect_out("R9 reset clears", 0, 0, 0);
    aresetn = 1; tick(4);
    run_cmp = 1;
    expect_out("R1 after second reset", 0, 0, 0);

    idle();
    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule